// File: doc/BRIEF.md
# ECC Masked-Write Read-Modify-Write Engine

This block fronts a banked storage array in which every 128-bit data word is kept together with 8 check bits of a single-error-correcting Hamming code. A command port with valid/ready handshake accepts reads, plain writes and byte-masked writes. A plain write (no mask bit set) is encoded and stored in the cycle it is accepted. A masked write cannot touch only part of a code word, so the engine runs an internal read-modify-write. It fetches the stored code word and repairs a single flipped bit. It then keeps the masked bytes, takes the unmasked bytes from the command, computes fresh check bits over the merged word and writes the whole code word back.

Each bank has its own sequencer with four states: IDLE, READ, MERGE and WBACK. A masked write accepted in IDLE moves the bank to READ. The bank then steps unconditionally READ → MERGE → WBACK → IDLE, one cycle each, and is busy in every state but IDLE. A command of any kind aimed at a busy bank is held with `cmd_ready` low. Commands to idle banks proceed, so masked writes spread over different banks can issue every cycle. Reads return corrected data one cycle after acceptance, with a flag when a bit was repaired. A diagnostic flip mask on plain writes lets a single stored bit be corrupted on purpose.

Top module: `ecc_rmw_engine`

## Requirements
- R1: A stored code word has 136 bits. Bit i-1 of the code word holds Hamming position i (1..136). Check bits sit at positions 1, 2, 4, …, 128, and data bits 0..127 fill the other positions in ascending order. A single flipped bit anywhere in the 136 is corrected on read, and `rd_fixed` is 1 with that read.
- R2: A write with `cmd_mask` all zero is stored at the accepting edge and never makes its bank busy. A read to the same word accepted in the very next cycle returns the new data.
- R3: A read accepted at a clock edge raises `rd_valid` for exactly the following cycle, with `rd_data` and `rd_fixed`. `rd_valid` is low in every other cycle, and `rd_fixed` is 0 for a clean word.
- R4: In a masked write, `cmd_mask[j]` = 1 keeps stored byte j (data bits 8j+7..8j). `cmd_mask[j]` = 0 replaces that byte with the same byte of `cmd_data`. A mask of all ones leaves the word unchanged.
- R5: A masked write holds `bank_busy` of its bank high for exactly three cycles (READ, MERGE, WBACK), starting the cycle after acceptance. Later reads see the merged word.
- R6: While a bank is busy, `cmd_ready` is low for any command addressed to it (read, plain write or masked write), so that command waits until the bank is idle.
- R7: Commands to idle banks are accepted while other banks are busy. Masked writes to different banks can be accepted on consecutive cycles with no stall, and at most one bank is in WBACK at a time.
- R8: A single-bit error in the stored word is corrected before the merge. `rmw_fixed` is high for the one WBACK cycle of that write. The written-back word carries fresh check bits and reads back with `rd_fixed` = 0.
- R9: After reset all banks are idle, `cmd_ready` is 1, `rd_valid` and `rmw_fixed` are 0, and every word reads as zero data with `rd_fixed` = 0.
- R10: `cmd_flip` is XORed into the 136-bit code word only on plain writes. A masked write ignores it, and that word later reads with `rd_fixed` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 3 | Target bank |
| cmd_addr | input | 4 | Word address within the bank |
| cmd_data | input | 128 | Write data |
| cmd_mask | input | 16 | Byte keep mask, 1 = keep stored byte; all zero = plain write |
| cmd_flip | input | 136 | Code-word bits to invert on a plain write (fault injection) |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 128 | Corrected read data |
| rd_fixed | output | 1 | A bit was corrected in the returned word |
| rmw_fixed | output | 1 | A bit was corrected during the current write-back |
| bank_busy | output | 8 | Per-bank read-modify-write in progress |

## Verification
The assertions follow the sequencing on every cycle. A masked write makes its bank busy for exactly three cycles, a plain write never makes it busy, and each accepted read gives one `rd_valid` pulse and nothing else. At most one bank becomes busy or writes back per cycle, the write-back slot belongs to a busy bank, and the correction pulse appears only during a write-back. Only the bench scenarios can show data correctness: byte merging under several masks, repair of an injected bit at data and check positions, stalls of exactly three cycles behind a busy bank, zero stalls for interleaved banks, and the flip mask having no effect on masked writes.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

    localparam int DATA_W = 128;
    localparam int CHK_W  = 8;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int BYTES  = DATA_W / 8;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_READ  = 2'd1,
        B_MERGE = 2'd2,
        B_WBACK = 2'd3
    } bank_st_t;

    // Scatter data bits onto non-power-of-two positions, check positions left zero.
    function automatic logic [CODE_W-1:0] code_place(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] code_extract(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = c[p-1];
                k++;
            end
        end
        return d;
    endfunction

    // XOR of the positions of all set bits.
    function automatic logic [CHK_W-1:0] code_syndrome(input logic [CODE_W-1:0] c);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (c[p-1]) s = s ^ CHK_W'(p);
        end
        return s;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_rmw_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] raw;
    logic [CHK_W-1:0]  syn;

    always_comb begin
        raw  = code_place(data);
        syn  = code_syndrome(raw);
        code = raw;
        for (int k = 0; k < CHK_W; k++) begin
            code[(1 << k) - 1] = syn[k];
        end
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import ecc_rmw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data,
    output logic              fixed
);
    logic [CHK_W-1:0]  syn;
    logic [CODE_W-1:0] repaired;

    always_comb begin
        syn      = code_syndrome(code);
        repaired = code;
        for (int p = 1; p <= CODE_W; p++) begin
            if (syn == CHK_W'(p)) repaired[p-1] = ~repaired[p-1];
        end
        data  = code_extract(repaired);
        fixed = (syn != '0);
    end
endmodule

// File: rtl/ecc_bank_seq.sv
module ecc_bank_seq
    import ecc_rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic in_merge,
    output logic in_wback
);
    bank_st_t st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= B_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt   = st;
        busy     = 1'b1;
        in_merge = 1'b0;
        in_wback = 1'b0;
        unique case (st)
            B_IDLE: begin
                busy = 1'b0;
                if (start) st_nxt = B_READ;
            end
            B_READ:  st_nxt = B_MERGE;
            B_MERGE: begin
                in_merge = 1'b1;
                st_nxt   = B_WBACK;
            end
            B_WBACK: begin
                in_wback = 1'b1;
                st_nxt   = B_IDLE;
            end
            default: st_nxt = B_IDLE;
        endcase
    end
endmodule

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine
    import ecc_rmw_pkg::*;
#(
    parameter  int NBANK  = 8,
    parameter  int DEPTH  = 16,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_wr,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [BYTES-1:0]  cmd_mask,
    input  logic [CODE_W-1:0] cmd_flip,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fixed,
    output logic              rmw_fixed,
    output logic [NBANK-1:0]  bank_busy
);
    localparam int IDX_W = BANK_W + ADDR_W;
    localparam int WORDS = NBANK * DEPTH;

    logic [CODE_W-1:0] mem [WORDS];

    logic              accept, rmw_go, plain_we, rd_go;
    logic [IDX_W-1:0]  cmd_idx;
    logic [NBANK-1:0]  start, in_merge, in_wback;

    // Shared pipeline: each phase is held by at most one bank per cycle.
    logic [IDX_W-1:0]  s1_idx, s2_idx, s3_idx;
    logic [DATA_W-1:0] s1_data, s2_data;
    logic [BYTES-1:0]  s1_mask, s2_mask;
    logic [CODE_W-1:0] s2_old, s3_code;

    logic [DATA_W-1:0] old_data, merged, rd_word;
    logic [CODE_W-1:0] merged_code, plain_code;
    logic              old_fix, rd_fix;

    assign cmd_idx   = {cmd_bank, cmd_addr};
    assign cmd_ready = !bank_busy[cmd_bank];
    assign accept    = cmd_valid && cmd_ready;
    assign rmw_go    = accept && cmd_wr && (|cmd_mask);
    assign plain_we  = accept && cmd_wr && !(|cmd_mask);
    assign rd_go     = accept && !cmd_wr;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign start[b] = rmw_go && (cmd_bank == BANK_W'(b));
        ecc_bank_seq u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start[b]),
            .busy     (bank_busy[b]),
            .in_merge (in_merge[b]),
            .in_wback (in_wback[b])
        );
    end

    ecc_encoder u_enc_plain (.data(cmd_data), .code(plain_code));
    ecc_decoder u_dec_read  (.code(mem[cmd_idx]), .data(rd_word), .fixed(rd_fix));
    ecc_decoder u_dec_old   (.code(s2_old), .data(old_data), .fixed(old_fix));
    ecc_encoder u_enc_merge (.data(merged), .code(merged_code));

    always_comb begin
        for (int j = 0; j < BYTES; j++) begin
            merged[8*j +: 8] = s2_mask[j] ? old_data[8*j +: 8] : s2_data[8*j +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_idx  <= '0;
            s1_data <= '0;
            s1_mask <= '0;
        end else if (rmw_go) begin
            s1_idx  <= cmd_idx;
            s1_data <= cmd_data;
            s1_mask <= cmd_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_idx    <= '0;
            s2_data   <= '0;
            s2_mask   <= '0;
            s2_old    <= '0;
            s3_idx    <= '0;
            s3_code   <= '0;
            rmw_fixed <= 1'b0;
        end else begin
            s2_idx    <= s1_idx;
            s2_data   <= s1_data;
            s2_mask   <= s1_mask;
            s2_old    <= mem[s1_idx];
            s3_idx    <= s2_idx;
            s3_code   <= merged_code;
            rmw_fixed <= (|in_merge) && old_fix;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (plain_we)    mem[cmd_idx] <= plain_code ^ cmd_flip;
            if (|in_wback)   mem[s3_idx]  <= s3_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_fixed <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) begin
                rd_data  <= rd_word;
                rd_fixed <= rd_fix;
            end
        end
    end
endmodule

// File: rtl/ecc_rmw_checker.sv
module ecc_rmw_checker #(
    parameter  int NBANK  = 8,
    parameter  int DEPTH  = 16,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int IDX_W  = BANK_W + ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_wr,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [15:0]       cmd_mask,
    input logic [NBANK-1:0]  bank_busy,
    input logic              rd_valid,
    input logic              rmw_fixed,
    input logic [NBANK-1:0]  wb_flags,
    input logic [IDX_W-1:0]  s3_idx
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    AST_MASK_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_wr && (|cmd_mask) |=> bank_busy[$past(cmd_bank)]); // R5

    for (genvar b = 0; b < NBANK; b++) begin : g_span
        AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bank_busy[b]) |=> bank_busy[b] ##1 bank_busy[b] ##1 !bank_busy[b]); // R5
    end

    AST_PLAIN_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_wr && !(|cmd_mask) |=> !bank_busy[$past(cmd_bank)]); // R2

    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !cmd_wr |=> rd_valid); // R3

    AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && !cmd_wr) |=> !rd_valid); // R3

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_busy & ~$past(bank_busy)) <= 1); // R7

    AST_WB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_flags)); // R7

    AST_WB_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb_flags) |-> bank_busy[s3_idx[IDX_W-1:ADDR_W]]); // R5

    AST_FIX_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_fixed |-> (|wb_flags)); // R8
endmodule

bind ecc_rmw_engine ecc_rmw_checker #(.NBANK(NBANK), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_wr    (cmd_wr),
    .cmd_bank  (cmd_bank),
    .cmd_mask  (cmd_mask),
    .bank_busy (bank_busy),
    .rd_valid  (rd_valid),
    .rmw_fixed (rmw_fixed),
    .wb_flags  (in_wback),
    .s3_idx    (s3_idx)
);

// File: tb/tb_ecc_rmw_engine.sv
`timescale 1ns/1ps
module tb_ecc_rmw_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic         cmd_wr = 1'b0;
    logic [2:0]   cmd_bank = '0;
    logic [3:0]   cmd_addr = '0;
    logic [127:0] cmd_data = '0;
    logic [15:0]  cmd_mask = '0;
    logic [135:0] cmd_flip = '0;
    logic         rd_valid;
    logic [127:0] rd_data;
    logic         rd_fixed;
    logic         rmw_fixed;
    logic [7:0]   bank_busy;

    ecc_rmw_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_mask(cmd_mask), .cmd_flip(cmd_flip), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_fixed(rd_fixed), .rmw_fixed(rmw_fixed), .bank_busy(bank_busy)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int stalls = 0;
    int cyc    = 0;
    logic [127:0] ref_mem [8][16];

    typedef struct packed {
        logic        wr;
        logic [2:0]  bank;
        logic [3:0]  addr;
        logic [7:0]  seed;
        logic [15:0] mask;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 4'd0,  8'h11, 16'h0000},
        '{1'b0, 3'd0, 4'd0,  8'h00, 16'h0000},
        '{1'b1, 3'd0, 4'd0,  8'h22, 16'h00FF},
        '{1'b0, 3'd0, 4'd0,  8'h00, 16'h0000},
        '{1'b1, 3'd1, 4'd5,  8'h33, 16'h0000},
        '{1'b1, 3'd1, 4'd5,  8'h44, 16'hFFFE},
        '{1'b0, 3'd1, 4'd5,  8'h00, 16'h0000},
        '{1'b1, 3'd7, 4'd15, 8'h55, 16'h0000},
        '{1'b1, 3'd7, 4'd15, 8'h66, 16'hAAAA},
        '{1'b0, 3'd7, 4'd15, 8'h00, 16'h0000},
        '{1'b1, 3'd2, 4'd3,  8'h77, 16'hFFFF},
        '{1'b0, 3'd2, 4'd3,  8'h00, 16'h0000},
        '{1'b1, 3'd6, 4'd9,  8'h88, 16'h0F0F},
        '{1'b0, 3'd6, 4'd9,  8'h00, 16'h0000},
        '{1'b1, 3'd0, 4'd0,  8'h99, 16'h8001},
        '{1'b0, 3'd0, 4'd0,  8'h00, 16'h0000}
    };

    function automatic logic [127:0] pat(input logic [7:0] s);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = s ^ (8'(i) * 8'h1D) ^ 8'(i);
        return r;
    endfunction

    function automatic logic [127:0] mrg(input logic [127:0] old_w, input logic [127:0] new_w,
                                          input logic [15:0] m);
        logic [127:0] r;
        for (int j = 0; j < 16; j++) r[8*j +: 8] = m[j] ? old_w[8*j +: 8] : new_w[8*j +: 8];
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=%0d expected<=%0d cycles", cyc, 20000);
            summary_and_end();
        end
    end

    // Called at a falling edge; returns at the falling edge after acceptance with valid low.
    task automatic issue(input logic wr, input logic [2:0] b, input logic [3:0] a,
                         input logic [127:0] d, input logic [15:0] m, input logic [135:0] f);
        cmd_valid = 1'b1;
        cmd_wr    = wr;
        cmd_bank  = b;
        cmd_addr  = a;
        cmd_data  = d;
        cmd_mask  = m;
        cmd_flip  = f;
        stalls    = 0;
        #1;
        while (!cmd_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic write_m(input logic [2:0] b, input logic [3:0] a, input logic [127:0] d,
                           input logic [15:0] m, input logic [135:0] f);
        issue(1'b1, b, a, d, m, f);
        ref_mem[b][a] = mrg(ref_mem[b][a], d, m);
    endtask

    task automatic read_chk(input string tag, input logic [2:0] b, input logic [3:0] a,
                            input logic exp_fix);
        issue(1'b0, b, a, '0, '0, '0);
        check({tag, " rd_valid"}, 128'(rd_valid), 128'd1);
        check({tag, " rd_data"}, rd_data, ref_mem[b][a]);
        check({tag, " rd_fixed"}, 128'(rd_fixed), 128'(exp_fix));
    endtask

    initial begin
        int tot;
        for (int b = 0; b < 8; b++)
            for (int a = 0; a < 16; a++) ref_mem[b][a] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check("R9 cmd_ready", 128'(cmd_ready), 128'd1);
        check("R9 bank_busy", 128'(bank_busy), 128'd0);
        check("R9 rd_valid", 128'(rd_valid), 128'd0);
        check("R9 rmw_fixed", 128'(rmw_fixed), 128'd0);
        read_chk("R9 empty word", 3'd5, 4'd11, 1'b0);

        // Table walk: R2 plain writes, R3 reads, R4 masked merges
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.wr) write_m(v.bank, v.addr, pat(v.seed), v.mask, '0);
            else      read_chk("R3 R4 table read", v.bank, v.addr, 1'b0);
        end

        // R2: plain write, no busy, immediate read with no stall
        write_m(3'd4, 4'd2, pat(8'hA1), 16'h0000, '0);
        check("R2 busy after plain", 128'(bank_busy), 128'd0);
        read_chk("R2 read after plain", 3'd4, 4'd2, 1'b0);
        check("R2 read stalls", 128'(stalls), 128'd0);

        // R5: three busy cycles, then R6 read stalled for three cycles
        write_m(3'd5, 4'd1, pat(8'hB2), 16'hF00F, '0);
        check("R5 busy cycle1", 128'(bank_busy[5]), 128'd1);
        read_chk("R5 merged read", 3'd5, 4'd1, 1'b0);
        check("R6 read stalls", 128'(stalls), 128'd3);

        write_m(3'd5, 4'd3, pat(8'hB3), 16'h0001, '0);
        @(negedge clk);
        check("R5 busy cycle2", 128'(bank_busy[5]), 128'd1);
        @(negedge clk);
        check("R5 busy cycle3", 128'(bank_busy[5]), 128'd1);
        @(negedge clk);
        check("R5 idle after three", 128'(bank_busy[5]), 128'd0);

        // R6: plain write behind a masked write to the same bank waits, then wins
        write_m(3'd5, 4'd2, pat(8'hC4), 16'h00F0, '0);
        write_m(3'd5, 4'd2, pat(8'hC5), 16'h0000, '0);
        check("R6 plain write stalls", 128'(stalls), 128'd3);
        read_chk("R6 plain after masked", 3'd5, 4'd2, 1'b0);

        // R7: masked writes to all banks back to back with no stall
        tot = 0;
        for (int b = 0; b < 8; b++) begin
            write_m(3'(b), 4'd7, pat(8'(8'h30 + b)), 16'h0F0F, '0);
            tot += stalls;
        end
        check("R7 interleaved stalls", 128'(tot), 128'd0);
        check("R7 all banks busy span", 128'(bank_busy[7]), 128'd1);
        for (int b = 0; b < 8; b++) read_chk("R7 interleaved read", 3'(b), 4'd7, 1'b0);

        // R1: single-bit corruption at a data, a check and the top position
        write_m(3'd3, 4'd4, pat(8'hD1), 16'h0000, 136'd1 << 70);
        read_chk("R1 data bit repaired", 3'd3, 4'd4, 1'b1);
        write_m(3'd3, 4'd5, pat(8'hD2), 16'h0000, 136'd1);
        read_chk("R1 check bit repaired", 3'd3, 4'd5, 1'b1);
        write_m(3'd3, 4'd9, pat(8'hD3), 16'h0000, 136'd1 << 135);
        read_chk("R1 top bit repaired", 3'd3, 4'd9, 1'b1);

        // R8: corrected before merge, flag in the write-back cycle only
        write_m(3'd3, 4'd6, pat(8'hE1), 16'h0000, 136'd1 << 20);
        write_m(3'd3, 4'd6, pat(8'hE2), 16'h00FF, '0);
        check("R8 no flag in READ", 128'(rmw_fixed), 128'd0);
        @(negedge clk);
        check("R8 no flag in MERGE", 128'(rmw_fixed), 128'd0);
        @(negedge clk);
        check("R8 flag in WBACK", 128'(rmw_fixed), 128'd1);
        @(negedge clk);
        check("R8 flag cleared", 128'(rmw_fixed), 128'd0);
        read_chk("R8 merged clean", 3'd3, 4'd6, 1'b0);

        // R10: flip mask ignored on masked writes
        write_m(3'd2, 4'd8, pat(8'hF1), 16'h0000, '0);
        write_m(3'd2, 4'd8, pat(8'hF2), 16'h3C3C, 136'd1 << 99);
        read_chk("R10 flip ignored on masked", 3'd2, 4'd8, 1'b0);

        summary_and_end();
    end
endmodule